// File: doc/BRIEF.md
# Stream-to-Memory Receive Descriptor Engine

This block is the receive side of one DMA channel. A byte stream, with a flag marking the last byte of each packet, arrives on a valid/ready input. The engine stores the bytes into memory buffers that are described by a linked chain of data descriptors. It fetches each descriptor over a single word-wide memory port. It closes the descriptor when the buffer is full or when a packet ends. On each close it writes the descriptor's status words back. It then either moves on to the next descriptor or stops at the end of the chain.

Software starts the engine by pulsing a start input with the address of the first descriptor and the address of the parent context word. Each descriptor is four 32-bit words at consecutive word addresses:
- base+0 holds the next descriptor pointer.
- base+4 holds the buffer start.
- base+8 holds the end address, which is one past the last writable byte.
- base+12 holds the control word.

In the control word, bit 0 marks the end of the chain, bit 4 requests an interrupt on close, and bit 11 is set by the engine when a packet ended in this buffer. In the parent context word, the engine sets bit 15 to record that the context is disabled. Four raw interrupt bits are kept; an acknowledge input clears them.

Top module: `dmaRxEngine`

## Requirements
- R1: After reset, inReady, memReq, irq, eolFlag and all irqRaw bits are 0.
- R2: Each accepted byte is written to the byte address in savedPtr. The write enables only byte lane savedPtr[1:0], with the byte placed in that lane. savedPtr then advances by one.
- R3: When savedPtr reaches the end address, the descriptor closes. The engine writes its end-address word (base+8) and then its control word (base+12), with bit 11 left clear if no packet end occurred.
- R4: A byte carrying inLast closes the descriptor at once. The end-address word is rewritten to the address just past that byte, control bit 11 is set in the written-back control word, and irqRaw bit 3 is set.
- R5: A close of a descriptor whose control bit 4 is set sets irqRaw bits 0 and 1. A close with bit 4 clear leaves them unchanged.
- R6: irq is 1 exactly when at least one irqRaw bit is 1.
- R7: Pulsing irqAck clears every irqRaw bit for which irqAck is 1, and leaves the other bits unchanged.
- R8: After write-back of a descriptor with control bit 0 set, eolFlag is set. The context word is read and written back with bit 15 set and its other bits kept. Afterwards inReady stays 0 and no data byte is stored until the next start, which clears eolFlag.
- R9: After write-back of a descriptor with control bit 0 clear, the engine fetches the descriptor at its next pointer. savedPtr then takes that descriptor's buffer start, which may be unaligned.
- R10: A byte with inLast that also exactly fills the buffer gives a single close, with both the fill actions and the packet-end actions applied.
- R11: inReady is 1 only while a data byte write is being offered to memory. It is 0 during descriptor fetch, descriptor write-back and context update. A read request holds its address until acknowledged.
- R12: A descriptor whose buffer start equals its end address closes immediately after its fetch, without consuming a byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Start pulse, accepted only when idle |
| startDesc | input | ADDR_W | Address of first descriptor |
| startCtx | input | ADDR_W | Address of parent context word |
| inValid | input | 1 | Stream byte valid |
| inData | input | 8 | Stream byte |
| inLast | input | 1 | Byte is last of its packet |
| inReady | output | 1 | Stream byte accepted this cycle when valid |
| memReq | output | 1 | Memory request |
| memWrite | output | 1 | Request is a write |
| memAddr | output | ADDR_W | Byte address |
| memBe | output | WORD_W/8 | Byte lane enables for writes |
| memWdata | output | WORD_W | Write data |
| memAck | input | 1 | Request accepted this cycle; read data valid |
| memRdata | input | WORD_W | Read data |
| irqAck | input | 4 | Clear mask for raw interrupt bits |
| irqRaw | output | 4 | Raw interrupt bits |
| irq | output | 1 | Interrupt line |
| eolFlag | output | 1 | Channel reached end of chain |
| savedPtr | output | ADDR_W | Current buffer write pointer |

## Verification
The pointer, the end address and the phase of the control sequence all live inside the block. A wrong value in any of them shows up at the memory port on the very next byte write or write-back: a byte lands at a wrong address or lane, an end-address word carries the wrong fill point, or a fetch goes to the wrong descriptor. A lost or spurious close shows up within a few cycles. It appears as an unexpected descriptor write or as inReady staying high when it should drop. A wrong end-of-chain state shows up as a stored byte after the refusal point, or as a context word without its disable bit.

// File: rtl/dmaRxPkg.sv
package dmaRxPkg;

  // word index of each descriptor field
  localparam int OFS_NEXT  = 0;
  localparam int OFS_BUF   = 1;
  localparam int OFS_AFTER = 2;
  localparam int OFS_CTRL  = 3;
  localparam int IRQ_W     = 4;

  typedef enum logic [2:0] {
    SEL_DATA,
    SEL_DESC_RD,
    SEL_WB_AFTER,
    SEL_WB_CTRL,
    SEL_CTX
  } memSelE;

  // strobes from control to datapath
  typedef struct packed {
    logic       start;
    logic       accept;
    logic       close;
    logic       closeEop;
    logic       ldWord;
    logic [1:0] wordIdx;
    logic       chain;
    logic       setEol;
    logic       ctxCap;
    memSelE     sel;
  } ctlStrobeT;

  // status from datapath to control
  typedef struct packed {
    logic fillsNext;
    logic emptyNow;
    logic descEol;
  } dpStatusT;

endpackage

// File: rtl/dmaRxCtl.sv
module dmaRxCtl
  import dmaRxPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      startReq,
  input  logic      inValid,
  input  logic      inLast,
  input  logic      memAck,
  input  dpStatusT  status,
  output ctlStrobeT stb,
  output logic      inReady,
  output logic      memReq,
  output logic      memWrite
);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_RUN,
    ST_WB_AFTER,
    ST_WB_CTRL,
    ST_CTX_RD,
    ST_CTX_WR
  } stateE;

  stateE      state, stateN;
  logic [1:0] wIdx, wIdxN;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      wIdx  <= '0;
    end else begin
      state <= stateN;
      wIdx  <= wIdxN;
    end
  end

  always_comb begin
    stb         = '0;
    stb.sel     = SEL_DATA;
    stb.wordIdx = wIdx;
    stateN      = state;
    wIdxN       = wIdx;
    inReady     = 1'b0;
    memReq      = 1'b0;
    memWrite    = 1'b0;
    case (state)
      ST_IDLE: begin
        if (startReq) begin
          stb.start = 1'b1;
          wIdxN     = '0;
          stateN    = ST_FETCH;
        end
      end
      ST_FETCH: begin
        memReq  = 1'b1;
        stb.sel = SEL_DESC_RD;
        if (memAck) begin
          stb.ldWord = 1'b1;
          if (wIdx == 2'(OFS_CTRL)) begin
            stateN = ST_RUN;
          end else begin
            wIdxN = wIdx + 2'd1;
          end
        end
      end
      ST_RUN: begin
        if (status.emptyNow) begin
          // zero-length buffer: close without consuming
          stb.close = 1'b1;
          stateN    = ST_WB_AFTER;
        end else begin
          memReq   = inValid;
          memWrite = 1'b1;
          stb.sel  = SEL_DATA;
          inReady  = memAck;
          if (inValid && memAck) begin
            stb.accept = 1'b1;
            if (status.fillsNext || inLast) begin
              stb.close    = 1'b1;
              stb.closeEop = inLast;
              stateN       = ST_WB_AFTER;
            end
          end
        end
      end
      ST_WB_AFTER: begin
        memReq   = 1'b1;
        memWrite = 1'b1;
        stb.sel  = SEL_WB_AFTER;
        if (memAck) stateN = ST_WB_CTRL;
      end
      ST_WB_CTRL: begin
        memReq   = 1'b1;
        memWrite = 1'b1;
        stb.sel  = SEL_WB_CTRL;
        if (memAck) begin
          if (status.descEol) begin
            stb.setEol = 1'b1;
            stateN     = ST_CTX_RD;
          end else begin
            stb.chain = 1'b1;
            wIdxN     = '0;
            stateN    = ST_FETCH;
          end
        end
      end
      ST_CTX_RD: begin
        memReq  = 1'b1;
        stb.sel = SEL_CTX;
        if (memAck) begin
          stb.ctxCap = 1'b1;
          stateN     = ST_CTX_WR;
        end
      end
      ST_CTX_WR: begin
        memReq   = 1'b1;
        memWrite = 1'b1;
        stb.sel  = SEL_CTX;
        if (memAck) stateN = ST_IDLE;
      end
      default: stateN = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/dmaRxDp.sv
module dmaRxDp
  import dmaRxPkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int WORD_W    = 32,
  parameter int EOL_BIT   = 0,
  parameter int INTR_BIT  = 4,
  parameter int INEOP_BIT = 11,
  parameter int DIS_BIT   = 15
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctlStrobeT           stb,
  input  logic [ADDR_W-1:0]   startDesc,
  input  logic [ADDR_W-1:0]   startCtx,
  input  logic [7:0]          inData,
  input  logic [WORD_W-1:0]   memRdata,
  input  logic [IRQ_W-1:0]    irqAck,
  output dpStatusT            status,
  output logic [ADDR_W-1:0]   memAddr,
  output logic [WORD_W/8-1:0] memBe,
  output logic [WORD_W-1:0]   memWdata,
  output logic [IRQ_W-1:0]    irqRaw,
  output logic                irq,
  output logic                eolFlag,
  output logic [ADDR_W-1:0]   savedPtr
);

  localparam int LANES  = WORD_W / 8;
  localparam int LANE_W = $clog2(LANES);

  logic [ADDR_W-1:0] curDesc, ctxAddr, nextPtr, bufPtr, afterPtr;
  logic [WORD_W-1:0] ctrlWord, ctxWord;
  logic [ADDR_W-1:0] bufPtrInc;
  logic [IRQ_W-1:0]  setBits, rawN;

  assign bufPtrInc = bufPtr + ADDR_W'(1);
  assign savedPtr  = bufPtr;

  assign status.fillsNext = (bufPtrInc == afterPtr);
  assign status.emptyNow  = (bufPtr == afterPtr);
  assign status.descEol   = ctrlWord[EOL_BIT];

  // memory address, lanes and write data by access kind
  always_comb begin
    memAddr  = bufPtr;
    memBe    = '1;
    memWdata = '0;
    case (stb.sel)
      SEL_DATA: begin
        memAddr  = bufPtr;
        memBe    = LANES'(1) << bufPtr[LANE_W-1:0];
        memWdata = {LANES{inData}};
      end
      SEL_DESC_RD: memAddr = curDesc + (ADDR_W'(stb.wordIdx) << LANE_W);
      SEL_WB_AFTER: begin
        memAddr  = curDesc + (ADDR_W'(OFS_AFTER) << LANE_W);
        memWdata = WORD_W'(afterPtr);
      end
      SEL_WB_CTRL: begin
        memAddr  = curDesc + (ADDR_W'(OFS_CTRL) << LANE_W);
        memWdata = ctrlWord;
      end
      SEL_CTX: begin
        memAddr  = ctxAddr;
        memWdata = ctxWord | (WORD_W'(1) << DIS_BIT);
      end
      default: memAddr = bufPtr;
    endcase
  end

  // raw interrupt update: a set in the same cycle wins over acknowledge
  always_comb begin
    setBits = '0;
    if (stb.close) begin
      setBits[0] = ctrlWord[INTR_BIT];
      setBits[1] = ctrlWord[INTR_BIT];
      setBits[3] = stb.closeEop;
    end
    rawN = (irqRaw & ~irqAck) | setBits;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curDesc  <= '0;
      ctxAddr  <= '0;
      nextPtr  <= '0;
      bufPtr   <= '0;
      afterPtr <= '0;
      ctrlWord <= '0;
      ctxWord  <= '0;
      eolFlag  <= 1'b0;
      irqRaw   <= '0;
      irq      <= 1'b0;
    end else begin
      if (stb.start) begin
        curDesc <= startDesc;
        ctxAddr <= startCtx;
        eolFlag <= 1'b0;
      end
      if (stb.ldWord) begin
        case (stb.wordIdx)
          2'(OFS_NEXT):  nextPtr  <= ADDR_W'(memRdata);
          2'(OFS_BUF):   bufPtr   <= ADDR_W'(memRdata);
          2'(OFS_AFTER): afterPtr <= ADDR_W'(memRdata);
          default:       ctrlWord <= memRdata;
        endcase
      end
      if (stb.accept) bufPtr <= bufPtrInc;
      if (stb.close) begin
        afterPtr <= stb.accept ? bufPtrInc : bufPtr;
        if (stb.closeEop) ctrlWord[INEOP_BIT] <= 1'b1;
      end
      if (stb.chain)  curDesc <= nextPtr;
      if (stb.setEol) eolFlag <= 1'b1;
      if (stb.ctxCap) ctxWord <= memRdata;
      irqRaw <= rawN;
      if (rawN != irqRaw) irq <= |rawN;
    end
  end

endmodule

// File: rtl/dmaRxEngine.sv
module dmaRxEngine
  import dmaRxPkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int WORD_W    = 32,
  parameter int EOL_BIT   = 0,
  parameter int INTR_BIT  = 4,
  parameter int INEOP_BIT = 11,
  parameter int DIS_BIT   = 15
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                startReq,
  input  logic [ADDR_W-1:0]   startDesc,
  input  logic [ADDR_W-1:0]   startCtx,
  input  logic                inValid,
  input  logic [7:0]          inData,
  input  logic                inLast,
  output logic                inReady,
  output logic                memReq,
  output logic                memWrite,
  output logic [ADDR_W-1:0]   memAddr,
  output logic [WORD_W/8-1:0] memBe,
  output logic [WORD_W-1:0]   memWdata,
  input  logic                memAck,
  input  logic [WORD_W-1:0]   memRdata,
  input  logic [3:0]          irqAck,
  output logic [3:0]          irqRaw,
  output logic                irq,
  output logic                eolFlag,
  output logic [ADDR_W-1:0]   savedPtr
);

  ctlStrobeT stb;
  dpStatusT  status;

  dmaRxCtl uCtl (
    .clk      (clk),
    .rstN     (rstN),
    .startReq (startReq),
    .inValid  (inValid),
    .inLast   (inLast),
    .memAck   (memAck),
    .status   (status),
    .stb      (stb),
    .inReady  (inReady),
    .memReq   (memReq),
    .memWrite (memWrite)
  );

  dmaRxDp #(
    .ADDR_W    (ADDR_W),
    .WORD_W    (WORD_W),
    .EOL_BIT   (EOL_BIT),
    .INTR_BIT  (INTR_BIT),
    .INEOP_BIT (INEOP_BIT),
    .DIS_BIT   (DIS_BIT)
  ) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .startDesc (startDesc),
    .startCtx  (startCtx),
    .inData    (inData),
    .memRdata  (memRdata),
    .irqAck    (irqAck),
    .status    (status),
    .memAddr   (memAddr),
    .memBe     (memBe),
    .memWdata  (memWdata),
    .irqRaw    (irqRaw),
    .irq       (irq),
    .eolFlag   (eolFlag),
    .savedPtr  (savedPtr)
  );

endmodule

// File: rtl/dmaRxChk.sv
module dmaRxChk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic              inReady,
  input logic              inLast,
  input logic              memReq,
  input logic              memWrite,
  input logic              memAck,
  input logic [ADDR_W-1:0] memAddr,
  input logic [3:0]        irqRaw,
  input logic              eolFlag,
  input logic [ADDR_W-1:0] savedPtr
);

  // R11: ready only while a data write is offered
  a_r11_ready_on_write: assert property (@(posedge clk) disable iff (!rstN)
    inReady |-> (memReq && memWrite));

  // R11: a pending read keeps its address
  a_r11_read_hold: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memWrite && !memAck) |=> (memReq && $stable(memAddr)));

  // R8: no acceptance once the chain end is reached
  a_r8_refuse_at_eol: assert property (@(posedge clk) disable iff (!rstN)
    eolFlag |-> !inReady);

  // R2: pointer steps by one per accepted byte
  a_r2_ptr_step: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> (savedPtr == $past(savedPtr) + ADDR_W'(1)));

  // R4: packet end raises raw bit 3
  a_r4_eop_raw: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady && inLast) |=> irqRaw[3]);

endmodule

bind dmaRxEngine dmaRxChk #(.ADDR_W(ADDR_W)) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .inReady  (inReady),
  .inLast   (inLast),
  .memReq   (memReq),
  .memWrite (memWrite),
  .memAck   (memAck),
  .memAddr  (memAddr),
  .irqRaw   (irqRaw),
  .eolFlag  (eolFlag),
  .savedPtr (savedPtr)
);

// File: tb/sim_dmaRxEngine.sv
module sim_dmaRxEngine;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startReq = 1'b0;
  logic [31:0] startDesc = '0;
  logic [31:0] startCtx = '0;
  logic        inValid = 1'b0;
  logic [7:0]  inData = '0;
  logic        inLast = 1'b0;
  logic        inReady;
  logic        memReq, memWrite, memAck;
  logic [31:0] memAddr, memWdata, memRdata;
  logic [3:0]  memBe;
  logic [3:0]  irqAck = '0;
  logic [3:0]  irqRaw;
  logic        irq, eolFlag;
  logic [31:0] savedPtr;

  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  dmaRxEngine u0 (.*);

  // word memory, 1 KB, stalls one cycle in three
  logic [31:0] mem [256];
  logic [1:0]  ackCnt = '0;
  always @(posedge clk) ackCnt <= (ackCnt == 2'd2) ? 2'd0 : ackCnt + 2'd1;
  assign memAck   = memReq && (ackCnt != 2'd0);
  assign memRdata = mem[memAddr[9:2]];

  always @(posedge clk) begin
    if (memReq && memAck && memWrite) begin
      for (int b = 0; b < 4; b++)
        if (memBe[b]) mem[memAddr[9:2]][8*b +: 8] <= memWdata[8*b +: 8];
    end
  end

  // scoreboard of expected data writes {addr, byte}
  logic [39:0] expQ [$];

  always @(negedge clk) begin
    if (rstN && memReq && memAck && memWrite && memBe != 4'hF) begin
      tests++;
      if (expQ.size() == 0) begin
        fails++;
        $display("FAIL R2/R8: unexpected data write addr=%h act be=%b exp none", memAddr, memBe);
      end else begin
        logic [39:0] e;
        e = expQ.pop_front();
        if (memAddr != e[39:8] || memBe != (4'b1 << e[9:8]) ||
            memWdata[8*e[9:8] +: 8] != e[7:0]) begin
          fails++;
          $display("FAIL R2: data write act addr=%h be=%b byte=%h exp addr=%h byte=%h",
                   memAddr, memBe, memWdata[8*e[9:8] +: 8], e[39:8], e[7:0]);
        end
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  // driver: one byte, pushes expectation, waits for handshake
  task automatic sendByte(input logic [31:0] addr, input logic [7:0] d, input logic last);
    expQ.push_back({addr, d});
    @(posedge clk); #1;
    inValid = 1'b1; inData = d; inLast = last;
    forever begin
      @(negedge clk);
      if (inReady) break;
    end
    @(posedge clk); #1;
    inValid = 1'b0; inLast = 1'b0;
  endtask

  task automatic startChain(input logic [31:0] d, input logic [31:0] c);
    @(posedge clk); #1;
    startReq = 1'b1; startDesc = d; startCtx = c;
    @(posedge clk); #1;
    startReq = 1'b0;
  endtask

  task automatic waitPtr(input logic [31:0] v);
    for (int n = 0; n < 400 && savedPtr !== v; n++) @(negedge clk);
  endtask

  task automatic waitEol();
    for (int n = 0; n < 400 && eolFlag !== 1'b1; n++) @(negedge clk);
    repeat (12) @(negedge clk);
  endtask

  task automatic pulseAck(input logic [3:0] m);
    @(posedge clk); #1; irqAck = m;
    @(posedge clk); #1; irqAck = '0;
    @(negedge clk);
  endtask

  task automatic setDesc(input int base, input logic [31:0] nxt, input logic [31:0] buff,
                         input logic [31:0] aft, input logic [31:0] ctl);
    mem[base/4]     = nxt;
    mem[base/4 + 1] = buff;
    mem[base/4 + 2] = aft;
    mem[base/4 + 3] = ctl;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: act=running exp=finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    mem[0] = 32'h0000_1234;                               // context A
    mem[1] = 32'h0000_0000;                               // context B
    setDesc(32'h40, 32'h50, 32'h100, 32'h106, 32'h10);   // interrupt on close
    setDesc(32'h50, 32'h60, 32'h201, 32'h209, 32'h0);    // unaligned start
    setDesc(32'h60, 32'h70, 32'h300, 32'h300, 32'h0);    // zero length
    setDesc(32'h70, 32'h00, 32'h380, 32'h384, 32'h11);   // end of chain + intr
    setDesc(32'h80, 32'h00, 32'h3c0, 32'h3c2, 32'h01);   // end of chain, no intr

    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 inReady", {31'b0, inReady}, 0);
    check("R1 memReq", {31'b0, memReq}, 0);
    check("R1 irq", {31'b0, irq}, 0);
    check("R1 eolFlag", {31'b0, eolFlag}, 0);
    check("R1 irqRaw", {28'b0, irqRaw}, 0);
    @(posedge clk); #1 rstN = 1'b1;

    startChain(32'h40, 32'h0);
    // R3/R5: six bytes fill the first buffer exactly
    for (int i = 0; i < 5; i++) sendByte(32'h100 + i, 8'hA0 + 8'(i), 1'b0);
    expQ.push_back({32'h105, 8'hA5});
    @(posedge clk); #1;
    inValid = 1'b1; inData = 8'hA5; inLast = 1'b0;
    forever begin @(negedge clk); if (inReady) break; end
    @(posedge clk); #1; inValid = 1'b0;
    @(negedge clk);
    // R11: write-back in progress, stream not ready
    check("R11 ready during writeback", {31'b0, inReady}, 0);
    check("R11 writeback full-word", {28'b0, memBe}, 32'hF);

    waitPtr(32'h201);
    check("R9 chained pointer", savedPtr, 32'h201);
    check("R5 raw after intr close", {28'b0, irqRaw}, 32'h3);
    check("R6 irq set", {31'b0, irq}, 1);
    pulseAck(4'b0001);
    check("R7 partial ack", {28'b0, irqRaw}, 32'h2);
    check("R6 irq still set", {31'b0, irq}, 1);

    // R4: packet of three ends early in second buffer
    sendByte(32'h201, 8'h11, 1'b0);
    sendByte(32'h202, 8'h22, 1'b0);
    sendByte(32'h203, 8'h33, 1'b1);
    waitPtr(32'h380);   // R12: zero-length descriptor passed, fourth fetched
    check("R12 skip to fourth", savedPtr, 32'h380);
    check("R4/R5 raw after eop close", {28'b0, irqRaw}, 32'hA);

    // R10: last byte also fills the buffer
    for (int i = 0; i < 3; i++) sendByte(32'h380 + i, 8'hC0 + 8'(i), 1'b0);
    sendByte(32'h383, 8'hC3, 1'b1);
    waitEol();
    check("R8 eolFlag", {31'b0, eolFlag}, 1);
    check("R10 raw both", {28'b0, irqRaw}, 32'hB);

    // R8: refusal at end of chain
    @(posedge clk); #1; inValid = 1'b1; inData = 8'hEE; inLast = 1'b0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      check("R8 ready held low", {31'b0, inReady}, 0);
    end
    @(posedge clk); #1; inValid = 1'b0;
    @(negedge clk);
    check("R8 pointer unchanged", savedPtr, 32'h384);

    pulseAck(4'b1011);
    check("R7 full ack", {28'b0, irqRaw}, 0);
    check("R6 irq cleared", {31'b0, irq}, 0);

    // descriptor write-back contents
    check("R3 first after", mem[32'h48/4], 32'h106);
    check("R3 first ctrl", mem[32'h4C/4], 32'h10);
    check("R4 second after", mem[32'h58/4], 32'h204);
    check("R4 second ctrl", mem[32'h5C/4], 32'h800);
    check("R12 third after", mem[32'h68/4], 32'h300);
    check("R12 third ctrl", mem[32'h6C/4], 32'h0);
    check("R10 fourth after", mem[32'h78/4], 32'h384);
    check("R10 fourth ctrl", mem[32'h7C/4], 32'h811);
    check("R8 context A", mem[0], 32'h9234);
    check("R2 stored word", mem[32'h100/4], 32'hA3A2A1A0);

    // restart: single end-of-chain descriptor without interrupt
    startChain(32'h80, 32'h4);
    @(negedge clk);
    check("R8 start clears eol", {31'b0, eolFlag}, 0);
    waitPtr(32'h3c0);
    sendByte(32'h3c0, 8'h5A, 1'b0);
    sendByte(32'h3c1, 8'hA5, 1'b0);
    waitEol();
    check("R5 no intr bits", {28'b0, irqRaw}, 0);
    check("R6 irq low", {31'b0, irq}, 0);
    check("R3 fifth after", mem[32'h88/4], 32'h3c2);
    check("R3 fifth ctrl", mem[32'h8C/4], 32'h1);
    check("R8 context B", mem[1], 32'h8000);
    check("R2 queue drained", expQ.size(), 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule